// File: doc/BRIEF.md
# Fill Character Stripper and Pixel Recovery

This block sits behind a serial video link deserializer. One 10-bit character arrives per clock, and a valid strobe qualifies it. When the link clock runs faster than the pixel rate, dummy characters pad the stream. At 2x, every data character is followed by one fill character. At 4x, every data character is followed by three fill characters. At 1x, no padding is used. The padding ratio is set so that the link clock stays in a fixed band whatever the pixel rate.

The block removes the fill characters and passes each real data character on with a one-cycle pixel strobe. It also checks that the padding keeps to its cadence. A slot counter, taken modulo the group length, expects data in slot 0 and fill in every other slot. Any violation raises a one-cycle error flag and drops the counter out of lock. Lock is regained on the first non-fill character that follows a fill character. While the blank indication is high, violations still break lock but do not raise the flag. Changing the ratio setting resets the counter and drops lock.

Top module: `fill_strip`

## Requirements
- R1: While rst_ni is low, pix_vld_o and err_o are 0 and pix_o is all zeros.
- R2: With mult_sel_i = 2'b00 (1x), every valid non-fill character in lock is presented on pix_o with pix_vld_o high.
- R3: With mult_sel_i = 2'b01 (2x), group length is 2: slot 0 holds data and slot 1 holds fill, and a pixel strobe is never followed directly by another.
- R4: With mult_sel_i = 2'b10 or 2'b11 (4x), group length is 4: slot 0 holds data and slots 1 to 3 hold fill.
- R5: The fill code is 10'b0001111010 (0x07A). It never produces a pixel strobe. A fill character in a data slot while in lock raises err_o for one cycle.
- R6: A non-fill character in a fill slot while in lock raises err_o for one cycle and produces no pixel. err_o and pix_vld_o are never high together.
- R7: Out of lock, no pixel and no error is produced until lock is regained. At 2x or 4x, lock is regained by a non-fill character whose preceding valid character was fill. At 1x, any non-fill character regains lock. The locking character is output as slot 0 data.
- R8: In a cycle where mult_sel_i differs from the setting held from the previous cycle, the character is dropped, the slot counter is cleared and lock is lost.
- R9: A violation whose character arrives with blank_i high breaks lock but leaves err_o low.
- R10: Cycles with char_vld_i low produce no pixel and no error, and they do not advance the slot counter.
- R11: pix_vld_o and err_o rise in the cycle after the character they refer to. pix_o then equals that character and holds until the next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 10 | Incoming character |
| char_vld_i | input | 1 | Character qualifier |
| mult_sel_i | input | 2 | Ratio: 00=1x, 01=2x, 10/11=4x |
| blank_i | input | 1 | High during blanking; masks err_o |
| pix_o | output | 10 | Retained data character |
| pix_vld_o | output | 1 | One strobe per recovered pixel |
| err_o | output | 1 | One-cycle cadence violation flag |

## Verification
Every result is due exactly one clock after the character that causes it. This holds for the pixel strobe, the retained character and the error flag. The bench model applies each character at the rising edge at which the design registers it. It compares all three outputs at the following falling edge, so each expectation lines up with the single register stage. Effects of a ratio change, or of lost lock, are observed as missing strobes on the later cycles, not as state read from inside the design.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    MUL_1X  = 2'b00,
    MUL_2X  = 2'b01,
    MUL_4X  = 2'b10,
    MUL_4XB = 2'b11
  } mult_e;

  function automatic logic [SLOT_W-1:0] last_slot(mult_e m);
    case (m)
      MUL_1X:  return SLOT_W'(0);
      MUL_2X:  return SLOT_W'(1);
      default: return SLOT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/fs_mode_track.sv
module fs_mode_track
  import fs_pkg::*;
#(
  parameter int                 CHAR_W    = 10,
  parameter logic [CHAR_W-1:0]  FILL_CODE = 10'b0001111010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              char_vld_i,
  input  logic [1:0]        mult_sel_i,
  output logic              is_fill_o,
  output logic              prev_fill_o,
  output logic              mode_chg_o,
  output logic [SLOT_W-1:0] last_slot_o
);
  mult_e mult_q;
  logic  prev_fill_q;

  assign is_fill_o   = (char_i == FILL_CODE);
  assign mode_chg_o  = (mult_e'(mult_sel_i) != mult_q);
  assign prev_fill_o = prev_fill_q;
  assign last_slot_o = last_slot(mult_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q      <= MUL_1X;
      prev_fill_q <= 1'b0;
    end else begin
      mult_q <= mult_e'(mult_sel_i);
      if (char_vld_i) prev_fill_q <= is_fill_o;
    end
  end
endmodule

// File: rtl/fs_slot_ctrl.sv
module fs_slot_ctrl
  import fs_pkg::*;
#(
  parameter bit BLANK_MASK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_vld_i,
  input  logic              blank_i,
  input  logic              is_fill_i,
  input  logic              prev_fill_i,
  input  logic              mode_chg_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output logic              accept_o,
  output logic              err_o
);
  logic              aligned_q, aligned_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              raw_err;
  logic              data_slot, no_fill_mode, can_lock;

  assign data_slot    = (slot_q == '0);
  assign no_fill_mode = (last_slot_i == '0);
  // lock point: first non-fill after fill (or any non-fill with no padding)
  assign can_lock     = !is_fill_i && (no_fill_mode || prev_fill_i);

  always_comb begin
    accept_o  = 1'b0;
    raw_err   = 1'b0;
    aligned_d = aligned_q;
    slot_d    = slot_q;
    if (mode_chg_i) begin
      aligned_d = 1'b0;
      slot_d    = '0;
    end else if (char_vld_i) begin
      if (!aligned_q) begin
        if (can_lock) begin
          accept_o  = 1'b1;
          aligned_d = 1'b1;
          slot_d    = no_fill_mode ? '0 : SLOT_W'(1);
        end
      end else if (data_slot == is_fill_i) begin
        raw_err   = 1'b1;
        aligned_d = 1'b0;
        slot_d    = '0;
      end else begin
        accept_o = data_slot;
        slot_d   = (slot_q == last_slot_i) ? '0 : SLOT_W'(slot_q + 1'b1);
      end
    end
  end

  generate
    if (BLANK_MASK) begin : g_mask
      assign err_o = raw_err && !blank_i;
    end else begin : g_nomask
      logic unused_blank;
      assign unused_blank = blank_i;
      assign err_o = raw_err;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      slot_q    <= '0;
    end else begin
      aligned_q <= aligned_d;
      slot_q    <= slot_d;
    end
  end
endmodule

// File: rtl/fs_out_reg.sv
module fs_out_reg #(
  parameter int CHAR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              accept_i,
  input  logic              err_i,
  output logic [CHAR_W-1:0] pix_o,
  output logic              pix_vld_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      pix_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      if (accept_i) pix_o <= char_i;
      pix_vld_o <= accept_i;
      err_o     <= err_i;
    end
  end
endmodule

// File: rtl/fill_strip.sv
module fill_strip
  import fs_pkg::*;
#(
  parameter int                CHAR_W     = 10,
  parameter logic [CHAR_W-1:0] FILL_CODE  = 10'b0001111010,
  parameter bit                BLANK_MASK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              char_vld_i,
  input  logic [1:0]        mult_sel_i,
  input  logic              blank_i,
  output logic [CHAR_W-1:0] pix_o,
  output logic              pix_vld_o,
  output logic              err_o
);
  logic              is_fill, prev_fill, mode_chg, accept, err;
  logic [SLOT_W-1:0] last_slot;

  fs_mode_track #(.CHAR_W(CHAR_W), .FILL_CODE(FILL_CODE)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_i      (char_i),
    .char_vld_i  (char_vld_i),
    .mult_sel_i  (mult_sel_i),
    .is_fill_o   (is_fill),
    .prev_fill_o (prev_fill),
    .mode_chg_o  (mode_chg),
    .last_slot_o (last_slot)
  );

  fs_slot_ctrl #(.BLANK_MASK(BLANK_MASK)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_vld_i  (char_vld_i),
    .blank_i     (blank_i),
    .is_fill_i   (is_fill),
    .prev_fill_i (prev_fill),
    .mode_chg_i  (mode_chg),
    .last_slot_i (last_slot),
    .accept_o    (accept),
    .err_o       (err)
  );

  fs_out_reg #(.CHAR_W(CHAR_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .char_i    (char_i),
    .accept_i  (accept),
    .err_i     (err),
    .pix_o     (pix_o),
    .pix_vld_o (pix_vld_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/fill_strip_chk.sv
module fill_strip_chk #(
  parameter int                CHAR_W     = 10,
  parameter logic [CHAR_W-1:0] FILL_CODE  = 10'b0001111010,
  parameter bit                BLANK_MASK = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CHAR_W-1:0] char_i,
  input logic              char_vld_i,
  input logic [1:0]        mult_sel_i,
  input logic              blank_i,
  input logic [CHAR_W-1:0] pix_o,
  input logic              pix_vld_o,
  input logic              err_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_no_fill_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> pix_o != FILL_CODE);

  assert_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> ($past(char_vld_i) && pix_o == $past(char_i)));

  assert_err_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_vld_o && err_o));

  assert_mode_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && mult_sel_i != $past(mult_sel_i)) |=> (!pix_vld_o && !err_o));

  assert_blank_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(BLANK_MASK && $past(blank_i)));

  assert_two_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(mult_sel_i) == 2'b01) |=> !pix_vld_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_vld_i |=> (!pix_vld_o && !err_o));
endmodule

bind fill_strip fill_strip_chk #(
  .CHAR_W(CHAR_W), .FILL_CODE(FILL_CODE), .BLANK_MASK(BLANK_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .char_i     (char_i),
  .char_vld_i (char_vld_i),
  .mult_sel_i (mult_sel_i),
  .blank_i    (blank_i),
  .pix_o      (pix_o),
  .pix_vld_o  (pix_vld_o),
  .err_o      (err_o)
);

// File: tb/sim_fill_strip.sv
module sim_fill_strip;
  localparam logic [9:0] FILL = 10'b0001111010;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] char_i = '0;
  logic       char_vld_i = 1'b0;
  logic [1:0] mult_sel_i = 2'b00;
  logic       blank_i = 1'b0;
  logic [9:0] pix_o;
  logic       pix_vld_o, err_o;

  int checks = 0, fails = 0;
  int dcnt = 0;
  bit run = 0, done = 0;
  string cur_req = "R2";

  always #2 clk_i = ~clk_i;

  fill_strip u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .char_i(char_i), .char_vld_i(char_vld_i),
    .mult_sel_i(mult_sel_i), .blank_i(blank_i),
    .pix_o(pix_o), .pix_vld_o(pix_vld_o), .err_o(err_o)
  );

  // behavioural reference
  int         m_mult, m_slot, m_len;
  bit         m_lock, m_pf, e_vld, e_err;
  logic [9:0] e_pix;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mult = 0; m_slot = 0; m_lock = 0; m_pf = 0;
      e_vld = 0; e_err = 0; e_pix = '0;
    end else begin
      bit f;
      f = (char_i == FILL);
      e_vld = 0; e_err = 0;
      m_len = (m_mult == 0) ? 1 : (m_mult == 1) ? 2 : 4;
      if (int'(mult_sel_i) != m_mult) begin
        m_mult = int'(mult_sel_i); m_lock = 0; m_slot = 0;
      end else if (char_vld_i) begin
        if (!m_lock) begin
          if (!f && (m_len == 1 || m_pf)) begin
            m_lock = 1; e_vld = 1; e_pix = char_i; m_slot = (m_len == 1) ? 0 : 1;
          end
        end else if ((m_slot == 0) == f) begin
          e_err = !blank_i; m_lock = 0; m_slot = 0;
        end else begin
          if (m_slot == 0) begin e_vld = 1; e_pix = char_i; end
          m_slot = (m_slot + 1) % m_len;
        end
      end
      if (char_vld_i) m_pf = f;
    end
  end

  always @(negedge clk_i) begin
    if (run) begin
      checks++;
      if (pix_vld_o !== e_vld) begin
        fails++;
        $display("FAIL %s pix_vld_o actual=%0b expected=%0b t=%0t", cur_req, pix_vld_o, e_vld, $time);
      end
      checks++;
      if (err_o !== e_err) begin
        fails++;
        $display("FAIL %s err_o actual=%0b expected=%0b t=%0t", cur_req, err_o, e_err, $time);
      end
      if (e_vld) begin
        checks++;
        if (pix_o !== e_pix) begin
          fails++;
          $display("FAIL %s pix_o actual=%h expected=%h t=%0t", cur_req, pix_o, e_pix, $time);
        end
      end
    end
  end

  function automatic logic [9:0] dchar(int i);
    logic [9:0] v;
    v = 10'((i * 53 + 17) & 10'h3ff);
    if (v == FILL) v = v + 10'd1;
    return v;
  endfunction

  task automatic send(logic [9:0] c, bit v);
    @(negedge clk_i);
    char_i = c; char_vld_i = v;
  endtask

  task automatic data();
    send(dchar(dcnt), 1'b1);
    dcnt++;
  endtask

  task automatic fill();
    send(FILL, 1'b1);
  endtask

  task automatic grp(int nf);
    data();
    for (int k = 0; k < nf; k++) fill();
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk_i);
    mult_sel_i = m; char_i = dchar(dcnt); char_vld_i = 1'b1; dcnt++;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (pix_vld_o !== 1'b0 || err_o !== 1'b0 || pix_o !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b/%b/%h expected=0/0/000", pix_vld_o, err_o, pix_o);
    end
    rst_ni = 1'b1;
    run = 1;
    // R2, R11: 1x stream
    cur_req = "R2/R11";
    for (int i = 0; i < 12; i++) data();
    // R5, R7: fill in 1x data slot, then relock on any non-fill
    cur_req = "R5/R7";
    fill(); data(); data();
    // R8, R3: switch to 2x
    cur_req = "R8/R3";
    set_mode(2'b01);
    data(); fill();
    for (int i = 0; i < 8; i++) grp(1);
    // R4: 4x
    cur_req = "R4/R8";
    set_mode(2'b10);
    fill();
    for (int i = 0; i < 6; i++) grp(3);
    // R6, R7: data in fill slot
    cur_req = "R6/R7";
    data(); fill(); data(); fill(); grp(3); grp(3);
    // R5: fill in data slot
    cur_req = "R5/R7";
    fill(); fill(); grp(3); grp(3);
    // R9: violations masked during blank
    cur_req = "R9";
    blank_i = 1'b1;
    data(); fill(); data(); fill(); grp(3); fill();
    blank_i = 1'b0;
    fill(); grp(3);
    // R10: gaps in 2x
    cur_req = "R10";
    set_mode(2'b01);
    fill(); data(); send('0, 1'b0); send(FILL, 1'b0); fill();
    send(dchar(3), 1'b0); data(); fill(); grp(1);
    // R4: alternate 4x code
    cur_req = "R4/R8";
    set_mode(2'b11);
    fill();
    for (int i = 0; i < 4; i++) grp(3);
    send('0, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i);
    run = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule